// File: doc/BRIEF.md
# Receive Frame FIFO Controller

This block sits between the receive side of an Ethernet MAC and a DMA engine. The MAC writes frames one word at a time and cannot be stalled. Each word holds 32 data bits, a 2-bit byte-count field and a last-word flag. The block stores the words in an inferred dual-port array and forwards them on a valid/ready read port. After the last word of each frame, it delivers a separate status word with the frame's length and error flag. These status words wait in a small side queue.

Two release policies are available, and a plain input selects between them. In the default pass-through policy, a frame starts to leave once sixteen words (64 bytes) of it are stored, or earlier if its last word has arrived. Once a frame has started, it streams to the end. In the hold-whole-frame policy, nothing of a frame leaves until its last word is stored. The policy is sampled only between frames.

If the array fills while a frame is being written, the frame is cut short, flagged and closed off cleanly. A frame that finds no room at its first word is discarded completely.

Top module: `rx_frame_fifo`

## Requirements
- R1: After reset, `out_valid_o` and `stat_valid_o` are low.
- R2: Each forwarded word reproduces the data, byte-count and last-word fields of the word the MAC wrote, in write order. Byte-count encoding: 00 means four valid bytes, and 01, 10 and 11 mean one, two and three.
- R3: With `sf_mode_i` low, a frame whose last word has not arrived is held until sixteen of its words are stored. It is offered on `out_valid_o` in the second cycle after the sixteenth word is written.
- R4: With `sf_mode_i` low, a frame shorter than sixteen words is held until its last word is stored, and is then released.
- R5: Once a frame has started to leave, its remaining words are forwarded as they arrive, with no new release decision, until its last word has been transferred.
- R6: After the last word of a frame is transferred, that frame's status is presented with `stat_valid_o` high for exactly one cycle. `out_valid_o` is low in that cycle, and no word of the next frame is offered before it.
- R7: With `sf_mode_i` high, no word of a frame is offered until its last word is stored.
- R8: `sf_mode_i` is sampled only between frames. Raising it while a frame is streaming does not stop that frame's later words from being offered.
- R9: A non-last word that arrives when exactly one slot is free is stored with the last-word flag forced to 1 and the byte-count field forced to 00. The frame's later words are dropped, and its status carries error 1 and the MAC's length.
- R10: A frame whose first word arrives when the array is full, or when the status queue is full, is discarded: no data word and no status word appear for it.
- R11: While `out_valid_o` is high and `out_ready_i` is low, `out_valid_o` stays high and the output word stays unchanged.
- R12: The status word carries the length and error flag that the MAC supplied with the frame's last word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sf_mode_i | input | 1 | 1 selects hold-whole-frame release, 0 selects pass-through release |
| in_valid_i | input | 1 | MAC word strobe |
| in_data_i | input | 32 | MAC data word |
| in_be_i | input | 2 | Valid-byte count of the word |
| in_eof_i | input | 1 | Last word of frame |
| in_len_i | input | LEN_W | Frame byte length, valid with the last word |
| in_err_i | input | 1 | Frame error from the MAC, valid with the last word |
| out_ready_i | input | 1 | DMA accepts a data word |
| out_valid_o | output | 1 | Data word offered |
| out_data_o | output | 32 | Offered data |
| out_be_o | output | 2 | Offered byte count |
| out_eof_o | output | 1 | Offered word is a frame's last |
| stat_valid_o | output | 1 | One-cycle status strobe |
| stat_len_o | output | LEN_W | Status frame length |
| stat_err_o | output | 1 | Status error flag |

## Verification
The bench builds the block with a 32-word array, a 4-entry status queue and the 64-byte release level. At that size, a 40-word frame overruns the array while the DMA is held off, which exercises truncation. A 32-word frame fills the array exactly, so the next frame meets a full array at its first word. Five one-word frames exceed the status queue. The release level stays at sixteen words, well inside the array, so the threshold, the mid-frame policy change and backpressure can each be observed before any overflow.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
  localparam int unsigned RXF_DW  = 32;
  localparam int unsigned RXF_BEW = 2;

  typedef struct packed {
    logic               eof;
    logic [RXF_BEW-1:0] be;
    logic [RXF_DW-1:0]  data;
  } rxf_word_t;

  typedef enum logic [1:0] {
    RD_IDLE   = 2'd0,
    RD_STREAM = 2'd1,
    RD_STAT   = 2'd2
  } rxf_rd_state_e;
endpackage

// File: rtl/rxf_dp_ram.sv
module rxf_dp_ram
  import rxf_pkg::*;
#(
  parameter int unsigned DEPTH = 256,
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic      clk,
  input  logic      we_i,
  input  logic [AW-1:0] waddr_i,
  input  rxf_word_t wdata_i,
  input  logic [AW-1:0] raddr_i,
  output rxf_word_t rdata_o
);
  rxf_word_t mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we_i) mem[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem[raddr_i];
endmodule

// File: rtl/rxf_stat_fifo.sv
module rxf_stat_fifo #(
  parameter int unsigned SDEPTH = 8,
  parameter int unsigned LEN_W  = 16,
  localparam int unsigned SAW = (SDEPTH > 1) ? $clog2(SDEPTH) : 1,
  localparam int unsigned SCW = $clog2(SDEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic             err_i,
  input  logic             pop_i,
  output logic             empty_o,
  output logic             full_o,
  output logic [LEN_W-1:0] len_o,
  output logic             err_o
);
  logic [LEN_W-1:0] len_q [SDEPTH];
  logic             err_q [SDEPTH];
  logic [SAW-1:0]   wp_q, wp_n, rp_q, rp_n;
  logic [SCW-1:0]   cnt_q, cnt_n;

  always_comb begin
    wp_n  = push_i ? ((wp_q == SAW'(SDEPTH - 1)) ? '0 : wp_q + 1'b1) : wp_q;
    rp_n  = pop_i  ? ((rp_q == SAW'(SDEPTH - 1)) ? '0 : rp_q + 1'b1) : rp_q;
    cnt_n = cnt_q + SCW'(push_i) - SCW'(pop_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else if (push_i || pop_i) begin
      wp_q  <= wp_n;
      rp_q  <= rp_n;
      cnt_q <= cnt_n;
    end
  end

  always_ff @(posedge clk) begin
    if (push_i) begin
      len_q[wp_q] <= len_i;
      err_q[wp_q] <= err_i;
    end
  end

  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == SCW'(SDEPTH));
  assign len_o   = len_q[rp_q];
  assign err_o   = err_q[rp_q];

  // R10
  stat_room_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push_i |-> !full_o);
  // R6
  stat_present_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pop_i |-> !empty_o);
endmodule

// File: rtl/rxf_rd_fsm.sv
module rxf_rd_fsm
  import rxf_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic go_i,
  input  logic data_avail_i,
  input  logic head_eof_i,
  input  logic out_ready_i,
  input  logic stat_avail_i,
  output logic out_valid_o,
  output logic rd_o,
  output logic stat_pop_o,
  output logic idle_o
);
  rxf_rd_state_e st_q, st_n;

  always_comb begin
    st_n        = st_q;
    out_valid_o = 1'b0;
    stat_pop_o  = 1'b0;
    unique case (st_q)
      RD_IDLE:   if (go_i) st_n = RD_STREAM;
      RD_STREAM: begin
        out_valid_o = data_avail_i;
        if (data_avail_i && out_ready_i && head_eof_i) st_n = RD_STAT;
      end
      RD_STAT: begin
        stat_pop_o = stat_avail_i;
        if (stat_avail_i) st_n = RD_IDLE;
      end
      default: st_n = RD_IDLE;
    endcase
  end

  assign rd_o   = out_valid_o && out_ready_i;
  assign idle_o = (st_q == RD_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          st_q <= RD_IDLE;
    else if (st_n != st_q) st_q <= st_n;
  end

  // R6
  stat_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stat_pop_o |=> !stat_pop_o && !out_valid_o);
endmodule

// File: rtl/rx_frame_fifo.sv
module rx_frame_fifo
  import rxf_pkg::*;
#(
  parameter int unsigned DEPTH    = 256,
  parameter int unsigned SDEPTH   = 8,
  parameter int unsigned CT_BYTES = 64,
  parameter int unsigned LEN_W    = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sf_mode_i,
  input  logic             in_valid_i,
  input  logic [31:0]      in_data_i,
  input  logic [1:0]       in_be_i,
  input  logic             in_eof_i,
  input  logic [LEN_W-1:0] in_len_i,
  input  logic             in_err_i,
  input  logic             out_ready_i,
  output logic             out_valid_o,
  output logic [31:0]      out_data_o,
  output logic [1:0]       out_be_o,
  output logic             out_eof_o,
  output logic             stat_valid_o,
  output logic [LEN_W-1:0] stat_len_o,
  output logic             stat_err_o
);
  localparam int unsigned AW       = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW       = $clog2(DEPTH + 1);
  localparam int unsigned CT_WORDS = CT_BYTES / 4;

  logic [AW-1:0] wr_ptr_q, wr_ptr_n, rd_ptr_q, rd_ptr_n;
  logic [CW-1:0] count_q, count_n, frm_q, frm_n;
  logic          in_frame_q, in_frame_n, skip_q, skip_n, disc_q, disc_n;
  logic          wr_en, force_eof, rd_en, go;
  logic          st_push, st_err, st_pop, st_empty, st_full, rd_idle;
  rxf_word_t     wr_word, rd_word;

  always_comb begin
    wr_en      = 1'b0;
    force_eof  = 1'b0;
    st_push    = 1'b0;
    st_err     = in_err_i;
    in_frame_n = in_frame_q;
    skip_n     = skip_q;
    disc_n     = disc_q;
    if (in_valid_i) begin
      if (!in_frame_q && (count_q == CW'(DEPTH) || st_full)) begin
        in_frame_n = !in_eof_i;
        skip_n     = !in_eof_i;
        disc_n     = !in_eof_i;
      end else if (skip_q) begin
        if (in_eof_i) begin
          st_push    = !disc_q;
          st_err     = 1'b1;
          in_frame_n = 1'b0;
          skip_n     = 1'b0;
          disc_n     = 1'b0;
        end
      end else begin
        wr_en      = 1'b1;
        st_push    = in_eof_i;
        in_frame_n = !in_eof_i;
        if (!in_eof_i && count_q == CW'(DEPTH - 1)) begin
          force_eof = 1'b1;
          skip_n    = 1'b1;
        end
      end
    end
  end

  assign wr_word.eof  = in_eof_i || force_eof;
  assign wr_word.be   = force_eof ? 2'b00 : in_be_i;
  assign wr_word.data = in_data_i;

  always_comb begin
    wr_ptr_n = wr_en ? ((wr_ptr_q == AW'(DEPTH - 1)) ? '0 : wr_ptr_q + 1'b1) : wr_ptr_q;
    rd_ptr_n = rd_en ? ((rd_ptr_q == AW'(DEPTH - 1)) ? '0 : rd_ptr_q + 1'b1) : rd_ptr_q;
    count_n  = count_q + CW'(wr_en) - CW'(rd_en);
    frm_n    = frm_q + CW'(wr_en && wr_word.eof) - CW'(rd_en && rd_word.eof);
    go       = (frm_q != '0) || (!sf_mode_i && count_q >= CW'(CT_WORDS));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      count_q  <= '0;
      frm_q    <= '0;
    end else if (wr_en || rd_en) begin
      wr_ptr_q <= wr_ptr_n;
      rd_ptr_q <= rd_ptr_n;
      count_q  <= count_n;
      frm_q    <= frm_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_frame_q <= 1'b0;
      skip_q     <= 1'b0;
      disc_q     <= 1'b0;
    end else if (in_valid_i) begin
      in_frame_q <= in_frame_n;
      skip_q     <= skip_n;
      disc_q     <= disc_n;
    end
  end

  rxf_dp_ram #(.DEPTH(DEPTH)) u_ram (
    .clk(clk), .we_i(wr_en), .waddr_i(wr_ptr_q), .wdata_i(wr_word),
    .raddr_i(rd_ptr_q), .rdata_o(rd_word)
  );

  rxf_stat_fifo #(.SDEPTH(SDEPTH), .LEN_W(LEN_W)) u_stat (
    .clk(clk), .rst_n(rst_n), .push_i(st_push), .len_i(in_len_i), .err_i(st_err),
    .pop_i(st_pop), .empty_o(st_empty), .full_o(st_full),
    .len_o(stat_len_o), .err_o(stat_err_o)
  );

  rxf_rd_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .go_i(go), .data_avail_i(count_q != '0),
    .head_eof_i(rd_word.eof), .out_ready_i(out_ready_i), .stat_avail_i(!st_empty),
    .out_valid_o(out_valid_o), .rd_o(rd_en), .stat_pop_o(st_pop), .idle_o(rd_idle)
  );

  assign stat_valid_o = st_pop;
  assign out_data_o   = rd_word.data;
  assign out_be_o     = rd_word.be;
  assign out_eof_o    = rd_word.eof;

  // R9
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> count_q < CW'(DEPTH));
  // R9
  frame_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frm_q <= count_q);
  // R11
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid_o && !out_ready_i |=> out_valid_o && $stable(out_data_o)
      && $stable(out_be_o) && $stable(out_eof_o));
  // R7
  sf_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_idle && sf_mode_i && frm_q == '0 |=> !out_valid_o);
endmodule

// File: tb/rx_frame_fifo_bench.sv
`timescale 1ns/100ps
module rx_frame_fifo_bench;
  localparam int unsigned LEN_W = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sf_mode = 1'b0;
  logic in_valid = 1'b0;
  logic [31:0] in_data = '0;
  logic [1:0] in_be = '0;
  logic in_eof = 1'b0;
  logic [LEN_W-1:0] in_len = '0;
  logic in_err = 1'b0;
  logic out_ready = 1'b0;
  logic out_valid, out_eof, stat_valid, stat_err;
  logic [31:0] out_data;
  logic [1:0] out_be;
  logic [LEN_W-1:0] stat_len;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  // item: {kind, len, err, eof, be, data}
  logic [52:0] exp_q[$];

  always #2.5 clk = ~clk;

  rx_frame_fifo #(.DEPTH(32), .SDEPTH(4), .CT_BYTES(64), .LEN_W(LEN_W)) u_rx_frame_fifo (
    .clk(clk), .rst_n(rst_n), .sf_mode_i(sf_mode), .in_valid_i(in_valid),
    .in_data_i(in_data), .in_be_i(in_be), .in_eof_i(in_eof), .in_len_i(in_len),
    .in_err_i(in_err), .out_ready_i(out_ready), .out_valid_o(out_valid),
    .out_data_o(out_data), .out_be_o(out_be), .out_eof_o(out_eof),
    .stat_valid_o(stat_valid), .stat_len_o(stat_len), .stat_err_o(stat_err)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [52:0] data_item(logic [31:0] d, logic [1:0] be, logic eof);
    return {1'b0, 16'h0, 1'b0, eof, be, d};
  endfunction

  function automatic logic [52:0] stat_item(logic [LEN_W-1:0] len, logic err);
    return {1'b1, len, err, 1'b0, 2'b00, 32'h0};
  endfunction

  // monitor / scoreboard
  logic hold_pend = 1'b0;
  logic [34:0] hold_word;
  always @(negedge clk) begin
    if (rst_n) begin
      if (hold_pend)  // R11
        check(out_valid && {out_eof, out_be, out_data} == hold_word, "R11 hold",
              {out_valid, out_eof, out_be, out_data}, {1'b1, hold_word});
      hold_pend = out_valid && !out_ready;
      hold_word = {out_eof, out_be, out_data};
      if (out_valid && stat_valid) check(1'b0, "R6 overlap", 1, 0);
      if (out_valid && out_ready) begin
        if (exp_q.size() == 0) check(1'b0, "R2 unexpected word", {out_eof, out_be, out_data}, 0);
        else begin
          logic [52:0] e;
          e = exp_q.pop_front();
          check(e == data_item(out_data, out_be, out_eof), "R2/R5/R6 data order",
                data_item(out_data, out_be, out_eof), e);
        end
      end
      if (stat_valid) begin
        if (exp_q.size() == 0) check(1'b0, "R6 unexpected status", {stat_len, stat_err}, 0);
        else begin
          logic [52:0] e;
          e = exp_q.pop_front();
          check(e == stat_item(stat_len, stat_err), "R6/R12 status",
                stat_item(stat_len, stat_err), e);
        end
      end
    end
  end

  // drives at posedge+1, returns at next posedge+1 with valid dropped
  task automatic send(logic [31:0] d, logic [1:0] be, logic eof, logic [LEN_W-1:0] len, logic err);
    in_valid = 1'b1; in_data = d; in_be = be; in_eof = eof; in_len = len; in_err = err;
    @(posedge clk); #1;
    in_valid = 1'b0; in_eof = 1'b0;
  endtask

  task automatic word(int id, int i, int n, logic err, bit expect_it);
    logic [31:0] d;
    logic [1:0] be;
    logic eof;
    d = {id[7:0], i[7:0], 16'hC3A5};
    be = 2'(i + id);
    eof = (i == n - 1);
    if (expect_it) begin
      exp_q.push_back(data_item(d, be, eof));
      if (eof) exp_q.push_back(stat_item(LEN_W'(n * 4), err));
    end
    send(d, be, eof, LEN_W'(n * 4), err);
  endtask

  task automatic frame(int id, int n, logic err, bit expect_it);
    for (int i = 0; i < n; i++) word(id, i, n, err, expect_it);
  endtask

  task automatic drain(string req);
    out_ready = 1'b1;
    for (int k = 0; k < 400 && exp_q.size() > 0; k++) @(posedge clk);
    repeat (5) @(posedge clk);
    @(negedge clk);
    check(exp_q.size() == 0 && !out_valid && !stat_valid, req, exp_q.size(), 0);
    @(posedge clk); #1;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R1
    check(!out_valid && !stat_valid, "R1 reset", {out_valid, stat_valid}, 0);
    @(posedge clk); #1;

    // R4: short frame held until last word, R12 error passes through
    out_ready = 1'b1;
    for (int i = 0; i < 3; i++) word(1, i, 4, 1'b1, 1'b1);
    repeat (5) @(negedge clk);
    check(!out_valid, "R4 held before last word", out_valid, 0);
    @(posedge clk); #1;
    word(1, 3, 4, 1'b1, 1'b1);
    drain("R4 short frame drained");

    // R3: threshold at sixteen words
    out_ready = 1'b0;
    for (int i = 0; i < 15; i++) word(2, i, 20, 1'b0, 1'b1);
    repeat (5) @(negedge clk);
    check(!out_valid, "R3 held below threshold", out_valid, 0);
    @(posedge clk); #1;
    word(2, 15, 20, 1'b0, 1'b1);
    @(negedge clk);
    check(!out_valid, "R3 not yet released", out_valid, 0);
    @(negedge clk);
    check(out_valid, "R3 released at threshold", out_valid, 1);
    // R8: raise hold-whole-frame mid-frame, streaming continues
    out_ready = 1'b1;
    repeat (20) @(posedge clk);
    #1 out_ready = 1'b0; sf_mode = 1'b1;
    word(2, 16, 20, 1'b0, 1'b1);
    @(negedge clk);
    check(out_valid, "R8 mode change mid-frame", out_valid, 1);
    @(posedge clk); #1;
    out_ready = 1'b1;
    for (int i = 17; i < 20; i++) word(2, i, 20, 1'b0, 1'b1);
    drain("R5 frame completed");

    // R7: hold-whole-frame release
    for (int i = 0; i < 20; i++) word(3, i, 21, 1'b0, 1'b1);
    repeat (5) @(negedge clk);
    check(!out_valid, "R7 held until last word", out_valid, 0);
    @(posedge clk); #1;
    word(3, 20, 21, 1'b0, 1'b1);
    drain("R7 frame drained");
    sf_mode = 1'b0;

    // R11: backpressure pattern during streaming
    fork
      frame(5, 24, 1'b0, 1'b1);
      for (int k = 0; k < 60; k++) begin
        out_ready = (k % 3 == 0);
        @(posedge clk); #1;
      end
    join
    drain("R11 backpressured frame drained");

    // R9: overrun truncates the frame
    out_ready = 1'b0;
    for (int i = 0; i < 40; i++) begin
      logic [31:0] d;
      d = {8'd9, i[7:0], 16'hC3A5};
      if (i < 31) exp_q.push_back(data_item(d, 2'(i + 9), 1'b0));
      else if (i == 31) exp_q.push_back(data_item(d, 2'b00, 1'b1));
      send(d, 2'(i + 9), i == 39, LEN_W'(160), 1'b0);
    end
    exp_q.push_back(stat_item(LEN_W'(160), 1'b1));
    drain("R9 truncated frame");

    // R10: array full at first word
    out_ready = 1'b0;
    frame(10, 32, 1'b0, 1'b1);
    frame(11, 3, 1'b0, 1'b0);
    drain("R10 full array discards frame");
    frame(12, 2, 1'b0, 1'b1);
    drain("R10 alignment after discard");

    // R10: status queue full at first word
    out_ready = 1'b0;
    for (int f = 20; f < 24; f++) frame(f, 1, 1'b0, 1'b1);
    frame(24, 1, 1'b0, 1'b0);
    drain("R10 full status queue discards frame");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule